// File: doc/BRIEF.md
# Narrow ROM read packer

This block turns one 32-bit word read request into a short series of reads on an external asynchronous memory whose data bus is 8, 16 or 32 bits wide. A width-select input, sampled when the request is accepted, picks the memory width. The block issues one, two or four narrow reads and puts each returned piece into its byte lane. It hands back a single 32-bit word with a one-cycle valid pulse.

Each narrow address is the request's word index shifted left into a 21-line external address bus. Address bits that fall off the top of the bus are dropped, so accesses wrap within the space. Pieces are always fetched from the lowest address upward, and the first piece lands in the least significant lane. The packing stays little-endian whatever the system endianness input says. The memory is treated as a read port that presents data a fixed, parameterised number of cycles after each read strobe.

Top module: `nrw_rom_packer`

## Requirements
- R1: After reset `req_ready` is 1, and `mem_rd` and `rsp_valid` are 0.
- R2: With `width_sel` = 2'b10 (32-bit) a request issues exactly one read on `mem_addr` = `req_addr[22:2]`, and `rsp_data` equals all 32 bits of `mem_data`.
- R3: With `width_sel` = 2'b01 (16-bit) two reads are issued, first at `{req_addr[21:2],1'b0}` and then at `{req_addr[21:2],1'b1}`. The first `mem_data[15:0]` lands in `rsp_data[15:0]` and the second in `rsp_data[31:16]`.
- R4: With `width_sel` = 2'b00 (8-bit) four reads are issued at `{req_addr[20:2],i}` for i = 0,1,2,3 in that order. Byte i from `mem_data[7:0]` lands in `rsp_data[8*i+7:8*i]`.
- R5: `req_addr[1:0]` has no effect: the access always covers the aligned word.
- R6: Bits shifted past the bus are dropped. In 8-bit mode `req_addr[22:21]` and in 16-bit mode `req_addr[22]` do not affect `mem_addr` or `rsp_data`.
- R7: `sys_big_endian` has no effect on the addresses, the read order or `rsp_data`.
- R8: `mem_rd` is high for one cycle per read, and `mem_addr` holds until that read's data is captured. Data is sampled exactly RD_LAT cycles after the strobe cycle, and each read takes RD_LAT+1 cycles. `rsp_valid` is a one-cycle pulse in cycle n*(RD_LAT+1)+1 after the accepting edge, where n is the number of reads.
- R9: A request is accepted only while `req_ready` is 1, which is only when idle. `req_valid` raised while busy starts no access and does not change the result.
- R10: In 8-bit and 16-bit modes the unused upper bits of `mem_data` do not reach `rsp_data`.
- R11: `width_sel` = 2'b11 behaves exactly like 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Word read request |
| req_ready | output | 1 | High when idle and able to accept |
| req_addr | input | 23 | Byte address of the requested word |
| width_sel | input | 2 | Memory width: 00 8-bit, 01 16-bit, 10/11 32-bit |
| sys_big_endian | input | 1 | System endianness setting (ignored) |
| rsp_valid | output | 1 | One-cycle pulse, word ready |
| rsp_data | output | 32 | Packed little-endian word |
| mem_rd | output | 1 | One-cycle strobe per narrow read |
| mem_addr | output | 21 | Shifted external address |
| mem_data | input | 32 | Memory read data (narrow data on low lanes) |

## Verification
Each width is driven with addresses whose line numbers differ in every lane, against a memory that returns distinct garbage in the upper lanes. This separates correct lane placement and read order from swapped, repeated or mis-masked pieces. Address pairs that differ only in the low two bits, or only in the bits shifted off the bus, should give identical strobes and data, which exposes wrong shifting or alignment. Toggling the endianness input, and raising a second request mid-access, must change nothing. Counting cycles to the valid pulse pins down the latency and sequencing.

// File: rtl/nrp_pkg.sv
package nrp_pkg;
  localparam int EA_W   = 21;
  localparam int BA_W   = EA_W + 2;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    MW_8   = 2'b00,
    MW_16  = 2'b01,
    MW_32  = 2'b10,
    MW_32X = 2'b11
  } mem_width_e;

  typedef logic [EA_W-1:0]   line_t;
  typedef logic [WORD_W-1:0] word_t;

  // number of narrow reads needed for one word
  function automatic logic [2:0] piece_count(mem_width_e w);
    case (w)
      MW_8:    return 3'd4;
      MW_16:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction

  // word index -> external line address of piece idx (top bits fall off)
  function automatic line_t piece_line(line_t widx, mem_width_e w, logic [1:0] idx);
    case (w)
      MW_8:    return {widx[EA_W-3:0], idx};
      MW_16:   return {widx[EA_W-2:0], idx[0]};
      default: return widx;
    endcase
  endfunction

  // place piece idx of the bus into its lane, little-endian always
  function automatic word_t merge_lane(word_t acc, word_t bus, mem_width_e w, logic [1:0] idx);
    word_t r;
    r = acc;
    case (w)
      MW_8:    r[8*idx +: 8]     = bus[7:0];
      MW_16:   r[16*idx[0] +: 16] = bus[15:0];
      default: r = bus;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/nrp_seq.sv
module nrp_seq
  import nrp_pkg::*;
#(
  parameter int RD_LAT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  mem_width_e width_in,
  output logic       req_ready,
  output logic       accept,
  output mem_width_e width_q,
  output logic [1:0] piece_idx,
  output logic       mem_rd,
  output logic       in_wait,
  output logic       capture,
  output logic       rsp_valid
);
  localparam int CW = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CW-1:0] LAT_M1 = CW'(RD_LAT - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_e;
  st_e           st;
  logic [CW-1:0] lat_cnt;
  logic          last_piece;

  assign req_ready  = (st == S_IDLE);
  assign accept     = req_ready && req_valid;
  assign mem_rd     = (st == S_ISSUE);
  assign in_wait    = (st == S_WAIT);
  assign capture    = in_wait && (lat_cnt == LAT_M1);
  assign rsp_valid  = (st == S_DONE);
  assign last_piece = (({1'b0, piece_idx} + 3'd1) == piece_count(width_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      lat_cnt   <= '0;
      piece_idx <= '0;
      width_q   <= MW_32;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          width_q   <= width_in;
          piece_idx <= '0;
          st        <= S_ISSUE;
        end
        S_ISSUE: begin
          lat_cnt <= '0;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (lat_cnt == LAT_M1) begin
            if (last_piece) st <= S_DONE;
            else begin
              piece_idx <= piece_idx + 2'd1;
              st        <= S_ISSUE;
            end
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
endmodule

// File: rtl/nrp_addr_gen.sv
module nrp_addr_gen
  import nrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  line_t      word_idx_in,
  input  mem_width_e width,
  input  logic [1:0] piece_idx,
  output line_t      mem_addr
);
  line_t widx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    widx_q <= '0;
    else if (load) widx_q <= word_idx_in;
  end

  assign mem_addr = piece_line(widx_q, width, piece_idx);
endmodule

// File: rtl/nrp_lane_pack.sv
module nrp_lane_pack
  import nrp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       capture,
  input  word_t      bus,
  input  mem_width_e width,
  input  logic [1:0] piece_idx,
  output word_t      word
);
  always_ff @(posedge clk) begin
    if (!rst_n)       word <= '0;
    else if (clear)   word <= '0;
    else if (capture) word <= merge_lane(word, bus, width, piece_idx);
  end

  a_r4_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (word == '0));
  a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !capture) |=> $stable(word));
endmodule

// File: rtl/nrw_rom_packer.sv
module nrw_rom_packer
  import nrp_pkg::*;
#(
  parameter int RD_LAT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [22:0] req_addr,
  input  logic [1:0]  width_sel,
  input  logic        sys_big_endian,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        mem_rd,
  output logic [20:0] mem_addr,
  input  logic [31:0] mem_data
);
  logic       accept, in_wait, capture;
  logic [1:0] piece_idx;
  mem_width_e width_q;
  logic [2:0] unused_inputs;

  // endianness and sub-word offset do not steer anything
  assign unused_inputs = {sys_big_endian, req_addr[1:0]};

  nrp_seq #(.RD_LAT(RD_LAT)) seq_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .width_in(mem_width_e'(width_sel)), .req_ready(req_ready),
    .accept(accept), .width_q(width_q), .piece_idx(piece_idx),
    .mem_rd(mem_rd), .in_wait(in_wait), .capture(capture),
    .rsp_valid(rsp_valid)
  );

  nrp_addr_gen addr_i (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .word_idx_in(req_addr[BA_W-1:2]), .width(width_q),
    .piece_idx(piece_idx), .mem_addr(mem_addr)
  );

  nrp_lane_pack pack_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .capture(capture),
    .bus(mem_data), .width(width_q), .piece_idx(piece_idx),
    .word(rsp_data)
  );

  // strobes seen since the last accept, for the read-count property
  logic [2:0] rd_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)      rd_seen <= '0;
    else if (accept) rd_seen <= '0;
    else if (mem_rd) rd_seen <= rd_seen + 3'd1;
  end

  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |-> $stable(mem_addr));
  a_r2_read_count: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rd_seen == piece_count(width_q)));
  a_r9_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);
endmodule

// File: tb/nrw_rom_packer_tb.sv
module nrw_rom_packer_tb_top;
  localparam int CLK_NS = 10;
  localparam int RD_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic [1:0]  width_sel = 2'b10;
  logic        sys_big_endian = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_rd;
  logic [20:0] mem_addr;
  logic [31:0] mem_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit run_done = 0;

  always #(CLK_NS/2) clk = ~clk;

  nrw_rom_packer #(.RD_LAT(RD_LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .width_sel(width_sel), .sys_big_endian(sys_big_endian),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // memory model: full-width content per line, valid only RD_LAT cycles after strobe
  function automatic logic [31:0] romv(logic [20:0] a);
    return ({11'b0, a} * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  logic [20:0] m_line = '0;
  int          m_age = 15;
  logic [20:0] rd_log [8];
  int          rd_n = 0;

  always @(negedge clk) begin
    if (mem_rd) begin
      m_line = mem_addr;
      m_age  = 0;
      if (rd_n < 8) rd_log[rd_n] = mem_addr;
      rd_n = rd_n + 1;
    end else if (m_age < 15) begin
      m_age = m_age + 1;
    end
  end
  assign mem_data = (m_age == RD_LAT) ? romv(m_line) : 32'hA5A5_A5A5;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected line for piece i, derived from byte-address shifting
  function automatic logic [20:0] exp_line(logic [22:0] a, logic [1:0] w, int i);
    logic [22:0] b;
    b = {a[22:2], 2'b00};
    case (w)
      2'b00:   begin b = b + 23'(i);     return b[20:0]; end
      2'b01:   begin b = b + 23'(2 * i); return b[21:1]; end
      default: return b[22:2];
    endcase
  endfunction

  function automatic int n_pieces(logic [1:0] w);
    return (w == 2'b00) ? 4 : (w == 2'b01) ? 2 : 1;
  endfunction

  function automatic logic [31:0] exp_word(logic [22:0] a, logic [1:0] w);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < n_pieces(w); i++) begin
      if (w == 2'b00)      r[8*i +: 8]   = romv(exp_line(a, w, i))[7:0];
      else if (w == 2'b01) r[16*i +: 16] = romv(exp_line(a, w, i))[15:0];
      else                 r = romv(exp_line(a, w, i));
    end
    return r;
  endfunction

  // one request; returns data and cycles to valid
  task automatic do_read(input logic [22:0] a, input logic [1:0] w, input logic be,
                         output logic [31:0] d, output int cyc);
    @(negedge clk);
    req_addr = a; width_sel = w; sys_big_endian = be; req_valid = 1'b1; rd_n = 0;
    @(negedge clk);
    req_valid = 1'b0; cyc = 1;
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    d = rsp_data;
  endtask

  task automatic run_case(input logic [22:0] a, input logic [1:0] w, input logic be, input string tag);
    logic [31:0] d;
    int cyc, n;
    n = n_pieces(w);
    do_read(a, w, be, d, cyc);
    chk(d == exp_word(a, w), {tag, " data"}, d, exp_word(a, w));
    chk(rd_n == n, {tag, " read count"}, 32'(rd_n), 32'(n));
    for (int i = 0; i < n && i < 8; i++)
      chk(rd_log[i] == exp_line(a, w, i), {tag, " line order"}, 32'(rd_log[i]), 32'(exp_line(a, w, i)));
    chk(cyc == n * (RD_LAT + 1) + 1, "R8 valid cycle", 32'(cyc), 32'(n * (RD_LAT + 1) + 1));
    @(negedge clk);
    chk(!rsp_valid, "R8 pulse width", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(mem_rd == 1'b0, "R1 strobe", 32'(mem_rd), 32'd0);
    chk(rsp_valid == 1'b0, "R1 valid", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_widths();
    run_case(23'h12_345C, 2'b10, 1'b0, "R2 32-bit");
    run_case(23'h6A_BC10, 2'b11, 1'b0, "R11 code 11");
    run_case(23'h12_345C, 2'b01, 1'b0, "R3 16-bit R10");
    run_case(23'h0F_0F08, 2'b00, 1'b0, "R4 8-bit R10");
  endtask

  task automatic t_low_bits();
    logic [31:0] d0, d1;
    int c;
    do_read(23'h05_5550, 2'b00, 1'b0, d0, c);
    do_read(23'h05_5553, 2'b00, 1'b0, d1, c);
    chk(d1 == d0, "R5 offset ignored", d1, d0);
    chk(rd_log[0] == exp_line(23'h05_5550, 2'b00, 0), "R5 first line", 32'(rd_log[0]), 32'(exp_line(23'h05_5550, 2'b00, 0)));
    run_case(23'h33_3332, 2'b01, 1'b0, "R5 16-bit offset");
  endtask

  task automatic t_wrap();
    logic [31:0] d0, d1;
    int c;
    do_read(23'h00_1234, 2'b00, 1'b0, d0, c);
    do_read(23'h60_1234, 2'b00, 1'b0, d1, c);
    chk(d1 == d0, "R6 8-bit wrap data", d1, d0);
    chk(rd_log[3] == 21'h00_1237, "R6 8-bit wrap line", 32'(rd_log[3]), 32'h0000_1237);
    do_read(23'h00_4448, 2'b01, 1'b0, d0, c);
    do_read(23'h40_4448, 2'b01, 1'b0, d1, c);
    chk(d1 == d0, "R6 16-bit wrap data", d1, d0);
    chk(rd_log[1] == 21'h00_2225, "R6 16-bit wrap line", 32'(rd_log[1]), 32'h0000_2225);
  endtask

  task automatic t_endian();
    run_case(23'h2B_CDE4, 2'b00, 1'b1, "R7 8-bit endian set");
    run_case(23'h2B_CDE4, 2'b01, 1'b1, "R7 16-bit endian set");
  endtask

  task automatic t_busy();
    logic [31:0] d;
    int cyc;
    @(negedge clk);
    req_addr = 23'h11_2230; width_sel = 2'b01; sys_big_endian = 1'b0; req_valid = 1'b1; rd_n = 0;
    @(negedge clk);
    req_addr = 23'h7F_FFFC; width_sel = 2'b00; cyc = 1;
    chk(req_ready == 1'b0, "R9 ready low busy", 32'(req_ready), 32'd0);
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (cyc == 3) req_valid = 1'b0;
    end
    d = rsp_data;
    chk(d == exp_word(23'h11_2230, 2'b01), "R9 result kept", d, exp_word(23'h11_2230, 2'b01));
    chk(rd_n == 2, "R9 no extra reads", 32'(rd_n), 32'd2);
    repeat (4) @(negedge clk);
    chk(rd_n == 2, "R9 no late access", 32'(rd_n), 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_widths();
    t_low_bits();
    t_wrap();
    t_endian();
    t_busy();
    run_done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!run_done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule